// File: doc/BRIEF.md
# Scaled 64-bit Machine Timer

This block holds a 64-bit machine time value as two 32-bit words and advances it whenever an update strobe arrives. It keeps the value of a free-running reference time counter at the last update. On each strobe it measures the ticks elapsed since then and multiplies them by an unsigned fixed-point scale factor. It drops the fraction and adds the whole part into the time value. The carry out of the low word goes into the high word. Every update also sets the two timer-poll bits at the top of a pending-interrupt word. Downstream logic uses those bits to compare the time against the timer compare values.

The block also holds the machine and supervisor 64-bit compare values, a cycle counter and a retired-instruction counter. A simple write port of select code, data and enable loads the time words, the compare words and the pending word. A freeze input from the run controller suspends all counting. While frozen, the reference point follows the reference counter, so the time spent stopped is never added after resume.

Top module: `mtimer_scaled`

## Requirements
- R1: While reset is asserted, every output is zero: both time words, both compare values, the cycle counter, the retired-instruction counter and the pending word. The stored reference point is also zero.
- R2: On a strobe with freeze low, the elapsed count is reference time minus the stored point, modulo 2^REF_W. The increment is floor(elapsed * scale / 2^16), because scale is unsigned with 16 fractional bits.
- R3: The increment is added to the low word. The low word keeps the sum modulo 2^32, and all bits above bit 31 of that sum are added to the high word. The high word wraps modulo 2^32 with no flag, so the pair behaves as one 64-bit counter modulo 2^64.
- R4: After every strobe with freeze low, the stored point equals the reference time of that cycle.
- R5: A strobe with freeze low ORs bits 31 and 30 into the pending word and keeps all other bits. A pending write (select 6) loads the data, and a strobe in the same cycle still ORs bits 31 and 30 over the written value.
- R6: While freeze is high, strobes have no effect: time, cycle and retired counts hold and no pending bit is set. The stored point tracks the reference time every frozen cycle, so the first strobe after resume counts only ticks elapsed since the last frozen cycle.
- R7: A write to the low time word (select 0) or high time word (select 1) takes priority over a strobe in the same cycle. The written word takes the data, the other word keeps its value, that strobe's elapsed ticks are discarded, and the point still moves. Time-word writes also work while frozen.
- R8: Selects 2 and 3 write the low and high halves of the machine compare value. Selects 4 and 5 write the low and high halves of the supervisor compare value. Other words are unaffected, and select 7 writes nothing.
- R9: The cycle counter adds one on every clock with freeze low. The retired counter adds one on every clock with the retire input high and freeze low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_time | input | REF_W | Free-running reference tick counter |
| upd | input | 1 | Update strobe |
| freeze | input | 1 | Suspend counting (run controller stop) |
| scale | input | SCALE_W | Unsigned scale factor, FRAC fractional bits |
| retire | input | 1 | One instruction retired this cycle |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 3 | Write select code (see R5, R7, R8) |
| wr_data | input | 32 | Write data |
| time_lo | output | 32 | Low time word |
| time_hi | output | 32 | High time word |
| mcmp | output | 64 | Machine compare value |
| scmp | output | 64 | Supervisor compare value |
| cycles | output | 64 | Cycle counter |
| retired | output | 64 | Retired-instruction counter |
| pend | output | 32 | Pending-interrupt word |

## Verification
Two collisions matter. The first is a time-word write landing in the same cycle as an update strobe. The second is a pending-word write coinciding with a strobe. Directed cases place each write exactly on a strobe cycle; the random phase issues writes and strobes independently, so both collisions recur many times under varied data. A bench model applies R7 and R5 to predict every cycle: it expects the written word, the untouched partner word and a moved point on a time-word collision. On a pending-word collision it expects the written value with bits 31 and 30 forced on.

// File: rtl/mtimer_scaled.sv
module mtimer_scaled #(
  parameter int REF_W   = 24,
  parameter int SCALE_W = 32,
  parameter int FRAC    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [REF_W-1:0]   ref_time,
  input  logic               upd,
  input  logic               freeze,
  input  logic [SCALE_W-1:0] scale,
  input  logic               retire,
  input  logic               wr_en,
  input  logic [2:0]         wr_sel,
  input  logic [31:0]        wr_data,
  output logic [31:0]        time_lo,
  output logic [31:0]        time_hi,
  output logic [63:0]        mcmp,
  output logic [63:0]        scmp,
  output logic [63:0]        cycles,
  output logic [63:0]        retired,
  output logic [31:0]        pend
);
  localparam int PROD_W = REF_W + SCALE_W;
  localparam int INC_W  = PROD_W - FRAC;
  localparam int SUM_W  = INC_W + 1;
  localparam int CRY_W  = SUM_W - 32;
  localparam logic [31:0] POLL = 32'hC000_0000;

  logic [REF_W-1:0] ref_pt;
  logic [REF_W-1:0] delta;
  logic [PROD_W-1:0] prod;
  logic [INC_W-1:0]  inc;
  logic [SUM_W-1:0]  sum;
  logic [CRY_W-1:0]  carry;
  logic tick, wr_lo, wr_hi;

  assign delta = ref_time - ref_pt;
  assign prod  = {{SCALE_W{1'b0}}, delta} * {{REF_W{1'b0}}, scale};
  assign inc   = prod[PROD_W-1:FRAC];
  assign sum   = {1'b0, inc} + {{(SUM_W-32){1'b0}}, time_lo};
  assign carry = sum[SUM_W-1:32];
  assign tick  = upd && !freeze;
  assign wr_lo = wr_en && wr_sel == 3'd0;
  assign wr_hi = wr_en && wr_sel == 3'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_lo <= '0;
      time_hi <= '0;
      ref_pt  <= '0;
    end else begin
      if (freeze || upd) ref_pt <= ref_time;
      if (wr_lo || wr_hi) begin
        if (wr_lo) time_lo <= wr_data;
        if (wr_hi) time_hi <= wr_data;
      end else if (tick) begin
        time_lo <= sum[31:0];
        time_hi <= time_hi + 32'(carry);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcmp <= '0;
      scmp <= '0;
      pend <= '0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          3'd2: mcmp[31:0]  <= wr_data;
          3'd3: mcmp[63:32] <= wr_data;
          3'd4: scmp[31:0]  <= wr_data;
          3'd5: scmp[63:32] <= wr_data;
          default: ;
        endcase
      end
      pend <= ((wr_en && wr_sel == 3'd6) ? wr_data : pend) | (tick ? POLL : 32'd0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycles  <= '0;
      retired <= '0;
    end else if (!freeze) begin
      cycles  <= cycles + 64'd1;
      if (retire) retired <= retired + 64'd1;
    end
  end

  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze && !wr_lo && !wr_hi |=> $stable(time_lo) && $stable(time_hi) && $stable(cycles) && $stable(retired));
  // R5
  poll_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && !freeze |=> pend[31:30] == 2'b11);
  // R7
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 3'd0 |=> time_lo == $past(wr_data));
  // R7
  wr_keep_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 3'd0 |=> time_hi == $past(time_hi));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd && !(wr_en && wr_sel <= 3'd1) |=> $stable(time_lo) && $stable(time_hi));
  // R9
  cycle_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> cycles != $past(cycles));
endmodule

// File: tb/sim_mtimer_scaled.sv
module sim_mtimer_scaled;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [23:0] ref_time = '0;
  logic upd = 1'b0, freeze = 1'b0, retire = 1'b0, wr_en = 1'b0;
  logic [31:0] scale = 32'h0001_0000;
  logic [2:0] wr_sel = 3'd7;
  logic [31:0] wr_data = '0;
  logic [31:0] time_lo, time_hi, pend;
  logic [63:0] mcmp, scmp, cycles, retired;

  int checks = 0;
  int errors = 0;
  logic [63:0] m_time, m_mcmp, m_scmp, m_cyc, m_ret;
  logic [31:0] m_pend;
  logic [23:0] m_pt;

  always #2 clk = ~clk;

  mtimer_scaled u0 (.clk(clk), .rst_n(rst_n), .ref_time(ref_time), .upd(upd),
    .freeze(freeze), .scale(scale), .retire(retire), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .time_lo(time_lo), .time_hi(time_hi), .mcmp(mcmp), .scmp(scmp),
    .cycles(cycles), .retired(retired), .pend(pend));

  function automatic logic [63:0] scaled_inc(input logic [23:0] d, input logic [31:0] s);
    logic [63:0] p;
    p = {40'd0, d} * {32'd0, s};
    return p >> 16;
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic compare_all(input string req);
    chk({req, " time"}, {time_hi, time_lo}, m_time);
    chk({req, " mcmp R8"}, mcmp, m_mcmp);
    chk({req, " scmp R8"}, scmp, m_scmp);
    chk({req, " cycles R9"}, cycles, m_cyc);
    chk({req, " retired R9"}, retired, m_ret);
    chk({req, " pend R5"}, pend, m_pend);
  endtask

  task automatic model_step();
    if (!freeze) begin
      m_cyc++;
      if (retire) m_ret++;
    end
    if (wr_en && wr_sel == 3'd0) m_time[31:0] = wr_data;
    else if (wr_en && wr_sel == 3'd1) m_time[63:32] = wr_data;
    else if (upd && !freeze) m_time = m_time + scaled_inc(ref_time - m_pt, scale);
    if (wr_en) begin
      case (wr_sel)
        3'd2: m_mcmp[31:0] = wr_data;
        3'd3: m_mcmp[63:32] = wr_data;
        3'd4: m_scmp[31:0] = wr_data;
        3'd5: m_scmp[63:32] = wr_data;
        3'd6: m_pend = wr_data;
        default: ;
      endcase
    end
    if (upd && !freeze) m_pend = m_pend | 32'hC000_0000;
    if (upd || freeze) m_pt = ref_time;
  endtask

  task automatic step(input string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all(req);
    upd = 1'b0; wr_en = 1'b0; wr_sel = 3'd7; retire = 1'b0;
  endtask

  task automatic do_upd(input logic [23:0] adv, input logic [31:0] s, input string req);
    ref_time = ref_time + adv; scale = s; upd = 1'b1;
    step(req);
  endtask

  task automatic do_wr(input logic [2:0] sel, input logic [31:0] d, input string req);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step(req);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_time = '0; m_mcmp = '0; m_scmp = '0; m_cyc = '0; m_ret = '0; m_pend = '0; m_pt = '0;
    repeat (3) @(negedge clk);
    compare_all("R1 reset");
    rst_n = 1'b1;

    do_upd(24'd5, 32'h0001_0000, "R2 unity");
    do_upd(24'd3, 32'h0000_8000, "R2 half floor");
    do_upd(24'd7, 32'h0001_4000, "R2 fraction");
    step("R4 idle");
    do_upd(24'd1, 32'h0001_0000, "R4 point moved");

    do_wr(3'd0, 32'hFFFF_FFF0, "R7 set lo");
    do_upd(24'd32, 32'h0001_0000, "R3 carry");
    do_upd(24'hFF_FFFF, 32'hFFFF_FFFF, "R3 big carry");
    do_wr(3'd1, 32'hFFFF_FFFF, "R7 set hi");
    do_wr(3'd0, 32'hFFFF_FFFF, "R7 set lo");
    do_upd(24'd2, 32'h0001_0000, "R3 hi wrap");

    ref_time = ref_time + 24'd100; upd = 1'b1; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 32'h1234_5678;
    step("R7 lo write vs upd");
    ref_time = ref_time + 24'd100; upd = 1'b1; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 32'h0000_00AA;
    step("R7 hi write vs upd");
    do_upd(24'd4, 32'h0001_0000, "R7 elapsed discarded");

    do_wr(3'd6, 32'h0000_0011, "R5 pend write");
    upd = 1'b1; wr_en = 1'b1; wr_sel = 3'd6; wr_data = 32'h0000_0022;
    step("R5 pend write vs upd");

    do_wr(3'd2, 32'hAAAA_0001, "R8 mcmp lo");
    do_wr(3'd3, 32'hAAAA_0002, "R8 mcmp hi");
    do_wr(3'd4, 32'hBBBB_0003, "R8 scmp lo");
    do_wr(3'd5, 32'hBBBB_0004, "R8 scmp hi");
    do_wr(3'd7, 32'hDEAD_BEEF, "R8 no target");

    do_wr(3'd6, 32'd0, "R5 clear");
    freeze = 1'b1;
    for (int i = 0; i < 5; i++) begin
      ref_time = ref_time + 24'd50; upd = 1'b1; retire = 1'b1;
      step("R6 frozen");
    end
    freeze = 1'b0;
    do_upd(24'd9, 32'h0001_0000, "R6 resume");
    retire = 1'b1;
    step("R9 retire");

    for (int i = 0; i < 3000; i++) begin
      ref_time = ref_time + 24'($urandom_range(0, 60000));
      upd = ($urandom_range(0, 2) != 0);
      freeze = ($urandom_range(0, 7) == 0);
      retire = $urandom_range(0, 1) == 1;
      scale = ($urandom_range(0, 3) == 0) ? $urandom : 32'($urandom_range(0, 32'h0004_0000));
      wr_en = ($urandom_range(0, 4) == 0);
      wr_sel = 3'($urandom_range(0, 7));
      wr_data = $urandom;
      step("R2 R3 R5 R6 R7 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule